// File: doc/BRIEF.md
# Post-Update Store Address Unit

This execution-stage unit serves store instructions that use post-increment addressing. For each accepted operation it produces a memory write request and a base-register writeback. The memory write goes to the base register's value as it was before the instruction. The base register then receives the sum of that old value and an offset. The offset comes from one of three places, chosen by the addressing form: a sign-extended 16-bit displacement, a 14-bit displacement scaled by four, or the index register.

The write request carries three things: a doubleword-aligned address, an 8-bit byte-enable mask using little-endian lane order, and the low-order bytes of the source register shifted into their lanes. Two conditions stop both the memory write and the writeback, and each raises its own flag. The first is a base register field of zero, which marks an invalid encoding. The second is an old base address that is not a multiple of the access size. No status registers are touched.

Operations enter through a valid/ready handshake and are registered once. The request, the writeback and the flags of an operation leave together one cycle after acceptance and are held while the consumer stalls.

Top module: `psu_store_unit`

## Requirements
- R1: With form code 0, `wb_data_o` equals `base_i` plus `disp_i` sign-extended from 16 bits.
- R2: With form code 1, `wb_data_o` equals `base_i` plus the value `{disp_i[13:0], 2'b00}` sign-extended from 16 bits; `disp_i[15:14]` have no effect.
- R3: With form code 2 or 3, `wb_data_o` equals `base_i` plus `index_i`.
- R4: `mem_addr_o` equals the unmodified `base_i` with its three low bits cleared, never the updated sum.
- R5: `size_i` codes 0/1/2/3 mean 1/2/4/8 bytes. The stored data is that many low-order bytes of `src_i` (bits 56..63, 48..63, 32..63 or all, counting bit 0 as the MSB). With lane L = `base_i[2:0]`, `mem_be_o` has bits L..L+n-1 set and `mem_data_o` holds the data shifted left by 8*L bits.
- R6: A `base_idx_i` of 0 raises `bad_form_o` and drives `mem_wr_o` and `wb_en_o` low.
- R7: When `base_i` is not a multiple of the access size, `misalign_o` is raised and `mem_wr_o` and `wb_en_o` are low.
- R8: `wb_idx_o` equals the accepted `base_idx_i`; `mem_wr_o` and `wb_en_o` are both high for any valid operation that is neither invalid nor misaligned.
- R9: `in_ready_o` is high exactly when no result is held or `out_ready_i` is high; a result shown with `out_ready_i` low stays unchanged on the next cycle. A result appears one cycle after acceptance.
- R10: While reset is asserted, and in the first cycle after it, `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present |
| in_ready_o | output | 1 | Operation can be accepted |
| size_i | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| form_i | input | 2 | Offset form (0 immediate, 1 scaled, 2/3 indexed) |
| base_idx_i | input | 5 | Base register number |
| disp_i | input | 16 | Displacement field |
| base_i | input | 64 | Base register value |
| index_i | input | 64 | Index register value |
| src_i | input | 64 | Source data register value |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | 64 | Doubleword-aligned write address |
| mem_be_o | output | 8 | Byte enables, lane 0 = address bits 2:0 zero |
| mem_data_o | output | 64 | Lane-aligned write data |
| wb_en_o | output | 1 | Base register writeback |
| wb_idx_o | output | 5 | Writeback register number |
| wb_data_o | output | 64 | Updated base value |
| bad_form_o | output | 1 | Invalid encoding (base register 0) |
| misalign_o | output | 1 | Old base not aligned to access size |

## Verification
Each operation's captured fields stay in the output register until the consumer takes them. If that state is corrupted, or the offset is chosen wrongly, the error shows at the ports one cycle after acceptance. It appears as a wrong `wb_data_o` or `mem_addr_o`, or as enables or data on the wrong lanes. A stall that lets the register change shows up on the next cycle as a different or lost result at the scoreboard. Bases are swept over all eight lane offsets, and the displacement is driven with sign bits both set and clear and with junk in the upper scaled bits. Invalid and misaligned operations are mixed into back-to-back streams so that a stale suppression flag would spill into a neighbouring result.

// File: rtl/psu_pkg.sv
`timescale 1ns/1ps
package psu_pkg;
  localparam int XLEN      = 64;
  localparam int DISP_W    = 16;
  localparam int SDISP_W   = 14;
  localparam int RIDX_W    = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    FM_IMM  = 2'd0,
    FM_SCL  = 2'd1,
    FM_IDX  = 2'd2,
    FM_IDX2 = 2'd3
  } form_e;
endpackage

// File: rtl/psu_offset.sv
`timescale 1ns/1ps
module psu_offset
  import psu_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int DW      = DISP_W,
  parameter int SDW     = SDISP_W
) (
  input  form_e          form_i,
  input  logic [DW-1:0]  disp_i,
  input  logic [W-1:0]   index_i,
  output logic [W-1:0]   off_o
);
  localparam int SCL_W = SDW + 2;

  logic [SCL_W-1:0] scl;
  assign scl = {disp_i[SDW-1:0], 2'b00};

  always_comb begin
    unique case (form_i)
      FM_IMM:  off_o = {{(W-DW){disp_i[DW-1]}}, disp_i};
      FM_SCL:  off_o = {{(W-SCL_W){scl[SCL_W-1]}}, scl};
      default: off_o = index_i;
    endcase
  end
endmodule

// File: rtl/psu_lane.sv
`timescale 1ns/1ps
module psu_lane
  import psu_pkg::*;
#(
  parameter int W      = XLEN,
  localparam int LANES  = W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  size_e             size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [W-1:0]      src_i,
  output logic [LANES-1:0]  be_o,
  output logic [W-1:0]      data_o,
  output logic              misalign_o
);
  logic [LANE_W:0]    nbytes;
  logic [LANES-1:0]   keep;
  logic [W-1:0]       masked;

  assign nbytes = (LANE_W+1)'(1) << size_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign keep[g]          = (g < int'(nbytes));
    assign masked[8*g +: 8] = keep[g] ? src_i[8*g +: 8] : 8'h00;
  end

  assign be_o       = keep << lane_i;
  assign data_o     = masked << {lane_i, 3'b000};
  assign misalign_o = |({1'b0, lane_i} & (nbytes - (LANE_W+1)'(1)));
endmodule

// File: rtl/psu_store_unit.sv
`timescale 1ns/1ps
module psu_store_unit
  import psu_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int DW  = DISP_W,
  parameter int SDW = SDISP_W,
  parameter int RW  = RIDX_W,
  localparam int LANES  = W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       size_i,
  input  logic [1:0]       form_i,
  input  logic [RW-1:0]    base_idx_i,
  input  logic [DW-1:0]    disp_i,
  input  logic [W-1:0]     base_i,
  input  logic [W-1:0]     index_i,
  input  logic [W-1:0]     src_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             mem_wr_o,
  output logic [W-1:0]     mem_addr_o,
  output logic [LANES-1:0] mem_be_o,
  output logic [W-1:0]     mem_data_o,
  output logic             wb_en_o,
  output logic [RW-1:0]    wb_idx_o,
  output logic [W-1:0]     wb_data_o,
  output logic             bad_form_o,
  output logic             misalign_o
);
  logic [W-1:0]     off;
  logic [LANES-1:0] be_c;
  logic [W-1:0]     data_c;
  logic             mis_c, bad_c, take;

  psu_offset #(.W(W), .DW(DW), .SDW(SDW)) u_off (
    .form_i  (form_e'(form_i)),
    .disp_i  (disp_i),
    .index_i (index_i),
    .off_o   (off)
  );

  psu_lane #(.W(W)) u_lane (
    .size_i     (size_e'(size_i)),
    .lane_i     (base_i[LANE_W-1:0]),
    .src_i      (src_i),
    .be_o       (be_c),
    .data_o     (data_c),
    .misalign_o (mis_c)
  );

  assign bad_c      = (base_idx_i == '0);
  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  logic vld_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      wr_q  <= in_valid_i && !bad_c && !mis_c;
    end
  end

  // payload needs no reset: qualified by vld_q
  always_ff @(posedge clk_i) begin
    if (take) begin
      mem_addr_o <= {base_i[W-1:LANE_W], LANE_W'(0)};  // old base, not the sum
      mem_be_o   <= be_c;
      mem_data_o <= data_c;
      wb_idx_o   <= base_idx_i;
      wb_data_o  <= base_i + off;
      bad_form_o <= bad_c;
      misalign_o <= mis_c;
    end
  end

  assign out_valid_o = vld_q;
  assign mem_wr_o    = vld_q && wr_q;
  assign wb_en_o     = vld_q && wr_q;
endmodule

// File: rtl/psu_store_unit_chk.sv
`timescale 1ns/1ps
module psu_store_unit_chk #(
  parameter int W  = 64,
  parameter int RW = 5,
  localparam int LANES = W / 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic             mem_wr_o,
  input logic [W-1:0]     mem_addr_o,
  input logic [LANES-1:0] mem_be_o,
  input logic [W-1:0]     mem_data_o,
  input logic             wb_en_o,
  input logic [RW-1:0]    wb_idx_o,
  input logic [W-1:0]     wb_data_o,
  input logic             bad_form_o,
  input logic             misalign_o
);
  p_reset_idle_r10: assert property (@(posedge clk_i)
    !rst_ni |=> !out_valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(mem_addr_o)
      && $stable(wb_data_o) && $stable(mem_be_o) && $stable(mem_data_o)
      && $stable(wb_idx_o));

  p_stall_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  p_bad_form_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && bad_form_o |-> !mem_wr_o && !wb_en_o);

  p_misalign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && misalign_o |-> !mem_wr_o && !wb_en_o);

  p_wb_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_idx_o != '0);

  p_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !bad_form_o && !misalign_o |-> mem_wr_o && wb_en_o);

  p_be_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $countones(mem_be_o) inside {1, 2, 4, 8});

  p_addr_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> mem_addr_o[2:0] == 3'b000);
endmodule

bind psu_store_unit psu_store_unit_chk #(.W(W), .RW(RW)) u_chk (.*);

// File: tb/sim_psu_store_unit.sv
`timescale 1ns/1ps
module sim_psu_store_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [1:0]  size_i = '0;
  logic [1:0]  form_i = '0;
  logic [4:0]  base_idx_i = '0;
  logic [15:0] disp_i = '0;
  logic [63:0] base_i = '0, index_i = '0, src_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic        mem_wr_o, wb_en_o, bad_form_o, misalign_o;
  logic [63:0] mem_addr_o, mem_data_o, wb_data_o;
  logic [7:0]  mem_be_o;
  logic [4:0]  wb_idx_o;

  always #4 clk = ~clk;  // 125 MHz

  psu_store_unit u0 (
    .clk_i(clk), .rst_ni, .in_valid_i, .in_ready_o, .size_i, .form_i,
    .base_idx_i, .disp_i, .base_i, .index_i, .src_i, .out_valid_o,
    .out_ready_i, .mem_wr_o, .mem_addr_o, .mem_be_o, .mem_data_o,
    .wb_en_o, .wb_idx_o, .wb_data_o, .bad_form_o, .misalign_o
  );

  typedef struct {
    logic        wr;
    logic [63:0] addr;
    logic [7:0]  be;
    logic [63:0] data;
    logic [4:0]  idx;
    logic [63:0] wb;
    logic        bad;
    logic        mis;
    string       tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic exp_t model(logic [1:0] sz, logic [1:0] fm, logic [4:0] ix,
                                 logic [15:0] d, logic [63:0] b, logic [63:0] x,
                                 logic [63:0] s, string tag);
    exp_t e;
    logic [63:0] off;
    logic [15:0] sc;
    int nb, ln;
    logic [63:0] msk;
    sc = {d[13:0], 2'b00};
    case (fm)
      2'd0:    off = {{48{d[15]}}, d};
      2'd1:    off = {{48{sc[15]}}, sc};
      default: off = x;
    endcase
    nb = 1 << sz;
    ln = int'(b[2:0]);
    msk = (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 64'd1);
    e.bad  = (ix == 0);
    e.mis  = (b & 64'(nb - 1)) != 0;
    e.wr   = !e.bad && !e.mis;
    e.addr = {b[63:3], 3'b000};
    e.be   = 8'(((16'd1 << nb) - 16'd1) << ln);
    e.data = (s & msk) << (8 * ln);
    e.idx  = ix;
    e.wb   = b + off;
    e.tag  = tag;
    return e;
  endfunction

  task automatic send(logic [1:0] sz, logic [1:0] fm, logic [4:0] ix,
                      logic [15:0] d, logic [63:0] b, logic [63:0] x,
                      logic [63:0] s, string tag);
    @(negedge clk);
    size_i = sz; form_i = fm; base_idx_i = ix; disp_i = d;
    base_i = b; index_i = x; src_i = s; in_valid_i = 1'b1;
    #3;
    while (!in_ready_o) begin
      @(negedge clk);
      #3;
    end
    q.push_back(model(sz, fm, ix, d, b, x, s, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_ni && out_valid_o && out_ready_i) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL R9: unexpected result wb=%h expected none", wb_data_o);
        end else begin
          exp_t e;
          logic ok;
          e = q.pop_front();
          ok = (mem_wr_o === e.wr) && (wb_en_o === e.wr) && (wb_idx_o === e.idx)
            && (bad_form_o === e.bad) && (misalign_o === e.mis);
          if (e.wr)
            ok = ok && (mem_addr_o === e.addr) && (mem_be_o === e.be)
              && (mem_data_o === e.data) && (wb_data_o === e.wb);
          if (!ok) begin
            bad++;
            $display("FAIL %s: wr=%b addr=%h be=%h data=%h idx=%0d wb=%h bad=%b mis=%b expected wr=%b addr=%h be=%h data=%h idx=%0d wb=%h bad=%b mis=%b",
              e.tag, mem_wr_o, mem_addr_o, mem_be_o, mem_data_o, wb_idx_o, wb_data_o,
              bad_form_o, misalign_o, e.wr, e.addr, e.be, e.data, e.idx, e.wb,
              e.bad, e.mis);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [63:0] SRC = 64'h0123_4567_89AB_CDEF;

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    #3;
    total++;
    if (out_valid_o !== 1'b0) begin
      bad++;
      $display("FAIL R10: out_valid=%b expected 0", out_valid_o);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    #3;
    total++;
    if (out_valid_o !== 1'b0) begin
      bad++;
      $display("FAIL R10: out_valid after release=%b expected 0", out_valid_o);
    end

    send(2'd0, 2'd0, 5'd3,  16'hFFFE, 64'h1003, 64'h0, SRC, "R1");
    send(2'd2, 2'd0, 5'd4,  16'h7FFC, 64'h4000_0000_0000_0008, 64'h0, SRC, "R1");
    send(2'd3, 2'd1, 5'd5,  16'h3FFF, 64'h8000, 64'h0, SRC, "R2");
    send(2'd3, 2'd1, 5'd6,  16'hC001, 64'h8008, 64'h0, SRC, "R2");
    send(2'd3, 2'd1, 5'd6,  16'h2000, 64'h10_0000, 64'h0, SRC, "R2");
    send(2'd1, 2'd2, 5'd7,  16'h1234, 64'h2006, 64'hFFFF_FFFF_FFFF_FFF0, SRC, "R3");
    send(2'd2, 2'd3, 5'd8,  16'h0000, 64'h100C, 64'h20, SRC, "R3");
    send(2'd2, 2'd0, 5'd9,  16'h0100, 64'h5004, 64'h0, SRC, "R4");
    for (int g = 0; g < 8; g++)
      send(2'd0, 2'd0, 5'd10, 16'h0001, 64'h3000 + 64'(g), 64'h0,
           SRC + 64'(g), "R5");
    send(2'd1, 2'd0, 5'd11, 16'h0002, 64'h3002, 64'h0, SRC, "R5");
    send(2'd3, 2'd2, 5'd12, 16'h0000, 64'h10, 64'h8, SRC, "R5");
    send(2'd2, 2'd0, 5'd0,  16'h0004, 64'h6000, 64'h0, SRC, "R6");
    send(2'd0, 2'd2, 5'd0,  16'h0000, 64'h6001, 64'h1, SRC, "R6");
    send(2'd1, 2'd0, 5'd13, 16'h0002, 64'h7001, 64'h0, SRC, "R7");
    send(2'd3, 2'd1, 5'd14, 16'h0001, 64'h7004, 64'h0, SRC, "R7");
    send(2'd2, 2'd0, 5'd15, 16'h0004, 64'h7006, 64'h0, SRC, "R7");
    send(2'd2, 2'd0, 5'd31, 16'h0008, 64'h7008, 64'h0, SRC, "R8");
    idle();
    repeat (3) @(negedge clk);

    // R9: stall holds the result and blocks input
    out_ready_i = 1'b0;
    send(2'd2, 2'd2, 5'd20, 16'h0000, 64'h9004, 64'h40, SRC, "R9");
    e = q[q.size()-1];
    idle();
    repeat (3) @(negedge clk);
    #3;
    total++;
    if (out_valid_o !== 1'b1 || in_ready_o !== 1'b0 || mem_addr_o !== e.addr
        || wb_data_o !== e.wb) begin
      bad++;
      $display("FAIL R9: stall valid=%b ready=%b addr=%h wb=%h expected 1 0 %h %h",
        out_valid_o, in_ready_o, mem_addr_o, wb_data_o, e.addr, e.wb);
    end
    @(negedge clk);
    out_ready_i = 1'b1;

    // back-to-back after stall
    send(2'd0, 2'd0, 5'd21, 16'hFFFF, 64'hA007, 64'h0, SRC, "R9");
    send(2'd1, 2'd0, 5'd0,  16'h0002, 64'hA000, 64'h0, SRC, "R6");
    send(2'd1, 2'd2, 5'd22, 16'h0000, 64'hA00E, 64'h2, SRC, "R3");
    idle();
    repeat (4) @(negedge clk);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R9: %0d results missing, expected 0", q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule